// File: doc/BRIEF.md
# Branch Trace Recorder with Debug Control

This block sits beside the retirement stage and watches one event port. Each event is a taken branch, an interrupt or an exception, and it carries a source address and a destination address. A debug control register decides what happens to each event. The event can be pushed into a small ring of recent source/destination pairs, and software reads that ring back by slot. It can be sent out as a trace message one cycle later. It can also be written as a record into a memory-resident buffer through a simple write port.

The buffer is described by three registers: a base, a running index and a limit. When the index reaches the limit, the buffer either wraps to the base or stops and raises a level interrupt. A performance-monitor interrupt request can freeze the ring, so the branches that led up to the event are kept. The block also drives a single-step trap indication when stepping is on taken branches instead of on instructions.

Software reaches every register through a word-wide register port. The write takes effect at the clock edge. The read is combinational from the address.

Top module: `branch_trace_unit`

## Requirements
- R1: With control bit 0 set and the ring not frozen, each event advances the top-of-stack pointer by one, modulo the depth. The event's source and destination are stored in the slot the new pointer names.
- R2: With control bit 1 set, `stepTrap` is high in the same cycle as an event that arrives while `trapFlag` is high. In every other case it is low.
- R3: With control bit 6 set, an event produces `msgValid` high in the next cycle, with `msgSrc`/`msgDst` equal to that event's addresses. With bit 6 clear, no message is produced.
- R4: With control bit 7 set, an accepted event produces a write on the port in the next cycle. The address is the index register value and the data is {destination, source}, with the source in the low half. The index then increments. Base, index and limit are read/write at 0x300, 0x301 and 0x302.
- R5: With control bit 8 clear, a record whose incremented index equals the limit sets the index back to the base.
- R6: With control bit 8 set, the record whose incremented index equals the limit raises `bufIrq`. `bufIrq` stays high and all later records are dropped until software writes the index register. That write clears `bufIrq` and logging resumes at the written index.
- R7: With control bit 11 set, a `pmiReq` sets frozen-status bit 14 on the following edge. While bit 14 is set, no event changes the ring. Writing the control register with bit 14 at zero clears the freeze.
- R8: The ring has 8 slots. The pointer resets to 0, so the first push lands in slot 1, and the ninth push overwrites the slot of the first. The pointer reads at 0x1C9. Slot i reads its source at 0x680+i and its destination at 0x6C0+i.
- R9: The control register sits at 0x1D9. Only bits 0, 1, 6, 7, 8, 11 and 14 hold a value. All other bits read as zero and ignore writes.
- R10: After reset, the control register, pointer, ring, index, `bufIrq`, `msgValid` and `memWrEn` are all zero.
- R11: A write held by `memWrReady` low keeps address and data stable. One more record waits in a skid register and goes out after the first. Records that arrive while the skid register is occupied are dropped and do not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Taken branch, interrupt or exception this cycle |
| evtSrc | input | ADDR_W | Source address of the event |
| evtDst | input | ADDR_W | Destination address of the event |
| trapFlag | input | 1 | Single-step trap flag from the core |
| pmiReq | input | 1 | Performance-monitor interrupt request |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational |
| stepTrap | output | 1 | Single-step-on-branch trap indication |
| msgValid | output | 1 | Trace message strobe |
| msgSrc | output | ADDR_W | Trace message source address |
| msgDst | output | ADDR_W | Trace message destination address |
| memWrEn | output | 1 | Buffer write request |
| memWrAddr | output | ADDR_W | Buffer record address |
| memWrData | output | 2*ADDR_W | Buffer record {destination, source} |
| memWrReady | input | 1 | Buffer write accepted |
| bufIrq | output | 1 | Buffer-full interrupt, level |

## Verification
The bench drives a long random run of events with stepping and messages on. A reference ring kept in the bench then catches a pointer that wraps wrongly or a slot written one place off after several laps. Directed cases go after the index reaching the limit in both modes. A design that wraps to zero instead of to the base, or that keeps writing once full, shows up at the write port and in the index read-back. The stalled-port case sends three back-to-back records, so a design that loses the skid record, or that advances the index for the dropped one, gives the wrong write order or the wrong final index. The freeze case checks that the pointer does not move after a monitor request and moves again once the status bit is cleared.

// File: rtl/btrace_pkg.sv
package btrace_pkg;
  localparam logic [11:0] ADDR_CTL   = 12'h1D9;
  localparam logic [11:0] ADDR_TOS   = 12'h1C9;
  localparam logic [11:0] ADDR_SRC0  = 12'h680;
  localparam logic [11:0] ADDR_DST0  = 12'h6C0;
  localparam logic [11:0] ADDR_BASE  = 12'h300;
  localparam logic [11:0] ADDR_INDEX = 12'h301;
  localparam logic [11:0] ADDR_LIMIT = 12'h302;

  localparam int BIT_LBR    = 0;
  localparam int BIT_STEP   = 1;
  localparam int BIT_MSG    = 6;
  localparam int BIT_LOG    = 7;
  localparam int BIT_INT    = 8;
  localparam int BIT_FRZEN  = 11;
  localparam int BIT_FROZEN = 14;

  localparam logic [31:0] CTL_MASK = (32'd1 << BIT_LBR) | (32'd1 << BIT_STEP) |
                                     (32'd1 << BIT_MSG) | (32'd1 << BIT_LOG) |
                                     (32'd1 << BIT_INT) | (32'd1 << BIT_FRZEN) |
                                     (32'd1 << BIT_FROZEN);

  typedef struct packed {
    logic pushLbr;
    logic emitMsg;
    logic logRec;
    logic stepTrap;
  } strobe_t;
endpackage

// File: rtl/btrace_ctrl.sv
module btrace_ctrl
  import btrace_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic              trapFlag,
  input  logic              pmiReq,
  input  logic              regWrEn,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWrData,
  input  logic              recCanTake,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] recAddr,
  output logic              bufIrq,
  output logic [31:0]       ctlState,
  output logic [31:0]       ctrlRdData
);
  logic [31:0]       ctlReg;
  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] limitReg;
  logic [ADDR_W-1:0] indexReg;
  logic              fullReg;
  logic [ADDR_W-1:0] indexInc;
  logic              wrCtl;
  logic              wrIndex;

  assign wrCtl    = regWrEn && (regAddr == ADDR_CTL);
  assign wrIndex  = regWrEn && (regAddr == ADDR_INDEX);
  assign indexInc = indexReg + ADDR_W'(1);

  // event routing decisions
  always_comb begin
    strb.pushLbr  = evtValid && ctlReg[BIT_LBR] && !ctlReg[BIT_FROZEN];
    strb.emitMsg  = evtValid && ctlReg[BIT_MSG];
    strb.logRec   = evtValid && ctlReg[BIT_LOG] && !fullReg && recCanTake;
    strb.stepTrap = evtValid && ctlReg[BIT_STEP] && trapFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= '0;
    end else if (wrCtl) begin
      ctlReg <= regWrData & CTL_MASK;
    end else if (ctlReg[BIT_FRZEN] && pmiReq) begin
      ctlReg[BIT_FROZEN] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      limitReg <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_BASE)  baseReg  <= ADDR_W'(regWrData);
      if (regAddr == ADDR_LIMIT) limitReg <= ADDR_W'(regWrData);
    end
  end

  // running index, wrap or stop at the limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= '0;
      fullReg  <= 1'b0;
    end else if (wrIndex) begin
      indexReg <= ADDR_W'(regWrData);
      fullReg  <= 1'b0;
    end else if (strb.logRec) begin
      if (indexInc == limitReg) begin
        if (ctlReg[BIT_INT]) begin
          indexReg <= indexInc;
          fullReg  <= 1'b1;
        end else begin
          indexReg <= baseReg;
        end
      end else begin
        indexReg <= indexInc;
      end
    end
  end

  assign recAddr  = indexReg;
  assign bufIrq   = fullReg;
  assign ctlState = ctlReg;

  always_comb begin
    case (regAddr)
      ADDR_CTL:   ctrlRdData = ctlReg;
      ADDR_BASE:  ctrlRdData = 32'(baseReg);
      ADDR_INDEX: ctrlRdData = 32'(indexReg);
      ADDR_LIMIT: ctrlRdData = 32'(limitReg);
      default:    ctrlRdData = '0;
    endcase
  end
endmodule

// File: rtl/btrace_datapath.sv
module btrace_datapath
  import btrace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [ADDR_W-1:0]   evtSrc,
  input  logic [ADDR_W-1:0]   evtDst,
  input  logic [ADDR_W-1:0]   recAddr,
  input  logic                memWrReady,
  input  logic [11:0]         regAddr,
  output logic [31:0]         dpRdData,
  output logic [$clog2(DEPTH)-1:0] tosOut,
  output logic                recCanTake,
  output logic                msgValid,
  output logic [ADDR_W-1:0]   msgSrc,
  output logic [ADDR_W-1:0]   msgDst,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [2*ADDR_W-1:0] memWrData
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int REC_W = 2 * ADDR_W;

  logic [ADDR_W-1:0] srcMem [DEPTH];
  logic [ADDR_W-1:0] dstMem [DEPTH];
  logic [PTR_W-1:0]  tos;
  logic [PTR_W-1:0]  tosNext;

  logic              outValid;
  logic [ADDR_W-1:0] outAddr;
  logic [REC_W-1:0]  outData;
  logic              skidValid;
  logic [ADDR_W-1:0] skidAddr;
  logic [REC_W-1:0]  skidData;
  logic              outFree;
  logic [REC_W-1:0]  newRec;

  assign tosNext = tos + PTR_W'(1);
  assign newRec  = {evtDst, evtSrc};
  assign outFree = !outValid || memWrReady;

  // ring of recent pairs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tos <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        srcMem[i] <= '0;
        dstMem[i] <= '0;
      end
    end else if (strb.pushLbr) begin
      tos             <= tosNext;
      srcMem[tosNext] <= evtSrc;
      dstMem[tosNext] <= evtDst;
    end
  end

  // trace message output
  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgSrc   <= '0;
      msgDst   <= '0;
    end else begin
      msgValid <= strb.emitMsg;
      if (strb.emitMsg) begin
        msgSrc <= evtSrc;
        msgDst <= evtDst;
      end
    end
  end

  // buffer write port with one skid slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outAddr   <= '0;
      outData   <= '0;
      skidValid <= 1'b0;
      skidAddr  <= '0;
      skidData  <= '0;
    end else if (skidValid && outFree) begin
      outValid  <= 1'b1;
      outAddr   <= skidAddr;
      outData   <= skidData;
      skidValid <= 1'b0;
    end else if (strb.logRec) begin
      if (outFree) begin
        outValid <= 1'b1;
        outAddr  <= recAddr;
        outData  <= newRec;
      end else begin
        skidValid <= 1'b1;
        skidAddr  <= recAddr;
        skidData  <= newRec;
      end
    end else if (outFree) begin
      outValid <= 1'b0;
    end
  end

  assign recCanTake = !skidValid;
  assign memWrEn    = outValid;
  assign memWrAddr  = outAddr;
  assign memWrData  = outData;
  assign tosOut     = tos;

  always_comb begin
    dpRdData = '0;
    if (regAddr == ADDR_TOS) dpRdData = 32'(tos);
    for (int i = 0; i < DEPTH; i++) begin
      if (regAddr == ADDR_SRC0 + 12'(i)) dpRdData = 32'(srcMem[i]);
      if (regAddr == ADDR_DST0 + 12'(i)) dpRdData = 32'(dstMem[i]);
    end
  end
endmodule

// File: rtl/branch_trace_unit.sv
module branch_trace_unit
  import btrace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                evtValid,
  input  logic [ADDR_W-1:0]   evtSrc,
  input  logic [ADDR_W-1:0]   evtDst,
  input  logic                trapFlag,
  input  logic                pmiReq,
  input  logic                regWrEn,
  input  logic [11:0]         regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  output logic                stepTrap,
  output logic                msgValid,
  output logic [ADDR_W-1:0]   msgSrc,
  output logic [ADDR_W-1:0]   msgDst,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [2*ADDR_W-1:0] memWrData,
  input  logic                memWrReady,
  output logic                bufIrq
);
  localparam int PTR_W = $clog2(DEPTH);

  strobe_t           strb;
  logic [ADDR_W-1:0] recAddr;
  logic              recCanTake;
  logic [31:0]       ctlState;
  logic [31:0]       ctrlRdData;
  logic [31:0]       dpRdData;
  logic [PTR_W-1:0]  tosValue;

  btrace_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .trapFlag(trapFlag),
    .pmiReq(pmiReq), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .recCanTake(recCanTake), .strb(strb),
    .recAddr(recAddr), .bufIrq(bufIrq), .ctlState(ctlState),
    .ctrlRdData(ctrlRdData)
  );

  btrace_datapath #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .evtSrc(evtSrc), .evtDst(evtDst),
    .recAddr(recAddr), .memWrReady(memWrReady), .regAddr(regAddr),
    .dpRdData(dpRdData), .tosOut(tosValue), .recCanTake(recCanTake),
    .msgValid(msgValid), .msgSrc(msgSrc), .msgDst(msgDst),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  assign regRdData = ctrlRdData | dpRdData;
  assign stepTrap  = strb.stepTrap;
endmodule

// File: rtl/branch_trace_unit_chk.sv
module branch_trace_unit_chk
  import btrace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     evtValid,
  input logic [ADDR_W-1:0]        evtSrc,
  input logic                     trapFlag,
  input logic                     regWrEn,
  input logic [11:0]              regAddr,
  input logic [31:0]              regRdData,
  input logic                     stepTrap,
  input logic                     msgValid,
  input logic [ADDR_W-1:0]        msgSrc,
  input logic                     memWrEn,
  input logic                     memWrReady,
  input logic [ADDR_W-1:0]        memWrAddr,
  input logic [2*ADDR_W-1:0]      memWrData,
  input logic                     bufIrq,
  input logic [31:0]              ctlState,
  input logic [$clog2(DEPTH)-1:0] tosValue
);
  localparam int PTR_W = $clog2(DEPTH);

  p_push_r1: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && ctlState[BIT_LBR] && !ctlState[BIT_FROZEN]
    |=> tosValue == PTR_W'($past(tosValue) + PTR_W'(1)));

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    stepTrap |-> evtValid && trapFlag && ctlState[BIT_STEP]);

  p_msg_r3: assert property (@(posedge clk) disable iff (!rstN)
    evtValid && ctlState[BIT_MSG] |=> msgValid && msgSrc == $past(evtSrc));

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufIrq && !(regWrEn && regAddr == ADDR_INDEX) |=> bufIrq);

  p_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctlState[BIT_FROZEN] |=> $stable(tosValue));

  p_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == ADDR_CTL |-> (regRdData & ~CTL_MASK) == 32'd0);

  p_stall_r11: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && !memWrReady |=> memWrEn && $stable(memWrAddr) && $stable(memWrData));
endmodule

bind branch_trace_unit branch_trace_unit_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtSrc(evtSrc),
  .trapFlag(trapFlag), .regWrEn(regWrEn), .regAddr(regAddr),
  .regRdData(regRdData), .stepTrap(stepTrap), .msgValid(msgValid),
  .msgSrc(msgSrc), .memWrEn(memWrEn), .memWrReady(memWrReady),
  .memWrAddr(memWrAddr), .memWrData(memWrData), .bufIrq(bufIrq),
  .ctlState(ctlState), .tosValue(tosValue)
);

// File: tb/branch_trace_unit_test.sv
`timescale 1ns/100ps
module branch_trace_unit_test;
  localparam int AW = 32;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          evtValid = 1'b0;
  logic [AW-1:0] evtSrc = '0;
  logic [AW-1:0] evtDst = '0;
  logic          trapFlag = 1'b0;
  logic          pmiReq = 1'b0;
  logic          regWrEn = 1'b0;
  logic [11:0]   regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          stepTrap;
  logic          msgValid;
  logic [AW-1:0] msgSrc;
  logic [AW-1:0] msgDst;
  logic          memWrEn;
  logic [AW-1:0] memWrAddr;
  logic [2*AW-1:0] memWrData;
  logic          memWrReady = 1'b1;
  logic          bufIrq;

  int vectors = 0;
  int fails = 0;

  branch_trace_unit #(.ADDR_W(AW), .DEPTH(DEPTH)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
    tick();
  endtask

  task automatic fire(input logic [AW-1:0] s, input logic [AW-1:0] d);
    evtValid = 1'b1; evtSrc = s; evtDst = d;
    tick();
    evtValid = 1'b0;
  endtask

  function automatic logic [2:0] ringNext(input logic [2:0] p);
    return p + 3'd1;
  endfunction

  logic [AW-1:0] mSrc [DEPTH];
  logic [AW-1:0] mDst [DEPTH];
  logic [2:0]    mTos;

  task automatic finish();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [31:0] rd;
    logic [2:0]  t0;
    void'($urandom(32'd7531));
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R10 reset state
    chk("R10 memWrEn", memWrEn, 0);
    chk("R10 msgValid", msgValid, 0);
    chk("R10 bufIrq", bufIrq, 0);
    regRead(12'h1D9, rd); chk("R10 ctl", rd, 0);
    regRead(12'h1C9, rd); chk("R10 tos", rd, 0);
    regRead(12'h301, rd); chk("R10 index", rd, 0);
    regRead(12'h683, rd); chk("R10 slot", rd, 0);

    // R9 writable bit mask
    regWrite(12'h1D9, 32'hFFFF_FFFF);
    regRead(12'h1D9, rd); chk("R9 mask", rd, 32'h0000_49C3);
    regWrite(12'h1D9, 32'h0);

    // random phase: ring, stepping, messages (R1 R2 R3 R8)
    for (int i = 0; i < DEPTH; i++) begin mSrc[i] = '0; mDst[i] = '0; end
    mTos = 3'd0;
    regWrite(12'h1D9, 32'h0000_0043);
    for (int n = 0; n < 300; n++) begin
      logic e, tf;
      logic [AW-1:0] s, d;
      e = 1'($urandom % 2); tf = 1'($urandom % 2);
      s = $urandom; d = $urandom;
      evtValid = e; trapFlag = tf; evtSrc = s; evtDst = d;
      #1;
      chk("R2 stepTrap", stepTrap, e & tf);
      tick();
      chk("R3 msgValid", msgValid, e);
      if (e) begin
        chk("R3 msgSrc", msgSrc, s);
        chk("R3 msgDst", msgDst, d);
        mTos = ringNext(mTos);
        mSrc[mTos] = s; mDst[mTos] = d;
      end
    end
    evtValid = 1'b0; trapFlag = 1'b0;
    regRead(12'h1C9, rd); chk("R8 tos", rd, 32'(mTos));
    for (int i = 0; i < DEPTH; i++) begin
      regRead(12'h680 + 12'(i), rd); chk("R8 src slot", rd, mSrc[i]);
      regRead(12'h6C0 + 12'(i), rd); chk("R1 dst slot", rd, mDst[i]);
    end

    // R2 stepping off: no trap
    regWrite(12'h1D9, 32'h0000_0001);
    evtValid = 1'b1; trapFlag = 1'b1; #1;
    chk("R2 step off", stepTrap, 0);
    tick(); evtValid = 1'b0; trapFlag = 1'b0;
    mTos = ringNext(mTos);

    // R3 message off
    fire(32'h55, 32'h66);
    chk("R3 no msg", msgValid, 0);
    mTos = ringNext(mTos);

    // R1 single push
    fire(32'h1234_0001, 32'h5678_0002);
    mTos = ringNext(mTos);
    regRead(12'h1C9, rd); chk("R1 tos", rd, 32'(mTos));
    regRead(12'h680 + 12'(mTos), rd); chk("R1 src", rd, 32'h1234_0001);

    // R7 freeze on monitor request
    regWrite(12'h1D9, 32'h0000_0801);
    pmiReq = 1'b1; tick(); pmiReq = 1'b0;
    regRead(12'h1D9, rd); chk("R7 frozen bit", rd, 32'h0000_4801);
    t0 = mTos;
    fire(32'hDEAD, 32'hBEEF);
    regRead(12'h1C9, rd); chk("R7 tos frozen", rd, 32'(t0));
    regRead(12'h680 + 12'(ringNext(t0)), rd); chk("R7 slot untouched", rd, mSrc[ringNext(t0)]);
    regWrite(12'h1D9, 32'h0000_0001);
    fire(32'hAA, 32'hBB);
    regRead(12'h1C9, rd); chk("R7 unfrozen", rd, 32'(ringNext(t0)));
    regWrite(12'h1D9, 32'h0);

    // R4/R5 buffer logging with wrap
    regWrite(12'h300, 32'h100);
    regWrite(12'h302, 32'h103);
    regWrite(12'h301, 32'h100);
    regWrite(12'h1D9, 32'h0000_0080);
    fire(32'hA0, 32'hB0);
    chk("R4 wr en", memWrEn, 1);
    chk("R4 wr addr", memWrAddr, 32'h100);
    chk("R4 wr data", memWrData, {32'hB0, 32'hA0});
    tick(); chk("R4 wr done", memWrEn, 0);
    fire(32'hA1, 32'hB1); chk("R4 addr 2", memWrAddr, 32'h101);
    fire(32'hA2, 32'hB2); chk("R4 addr 3", memWrAddr, 32'h102);
    regRead(12'h301, rd); chk("R5 wrap index", rd, 32'h100);
    fire(32'hA3, 32'hB3); chk("R5 wrap addr", memWrAddr, 32'h100);

    // R6 full interrupt
    regWrite(12'h301, 32'h100);
    regWrite(12'h1D9, 32'h0000_0180);
    fire(1, 2); fire(3, 4);
    chk("R6 irq early", bufIrq, 0);
    fire(5, 6);
    chk("R6 irq set", bufIrq, 1);
    tick();
    fire(7, 8);
    chk("R6 dropped", memWrEn, 0);
    chk("R6 irq held", bufIrq, 1);
    regRead(12'h301, rd); chk("R6 index stop", rd, 32'h103);
    regWrite(12'h301, 32'h101);
    chk("R6 irq clear", bufIrq, 0);
    fire(9, 10);
    chk("R6 resume", memWrAddr, 32'h101);
    chk("R6 resume en", memWrEn, 1);
    tick();

    // R11 stalled port with skid
    regWrite(12'h302, 32'h110);
    regWrite(12'h301, 32'h100);
    regWrite(12'h1D9, 32'h0000_0080);
    memWrReady = 1'b0;
    evtValid = 1'b1; evtSrc = 32'hC1; evtDst = 32'hD1; tick();
    evtSrc = 32'hC2; evtDst = 32'hD2; tick();
    evtSrc = 32'hC3; evtDst = 32'hD3; tick();
    evtValid = 1'b0;
    chk("R11 first held", memWrData, {32'hD1, 32'hC1});
    chk("R11 first addr", memWrAddr, 32'h100);
    tick();
    chk("R11 stable", memWrData, {32'hD1, 32'hC1});
    memWrReady = 1'b1;
    tick();
    chk("R11 skid out", memWrData, {32'hD2, 32'hC2});
    chk("R11 skid addr", memWrAddr, 32'h101);
    tick();
    chk("R11 drained", memWrEn, 0);
    regRead(12'h301, rd); chk("R11 drop index", rd, 32'h102);

    finish();
  end
endmodule